// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel flash device. Once a program or erase command has been issued elsewhere, it watches for the device's internal write to finish. It does this by reading the target location again and again through a simple synchronous read port. Two detection methods are offered, picked by an input when the job starts:

- **Data-bit polling.** The top data bit of each read is compared with the value it will hold once the write is over.
- **Toggle detection.** The second-highest data bit is compared between consecutive reads. The write is over once that bit stops flipping.

The device finishes its write at a moment unrelated to the host. A single read can therefore straddle the finish and give a misleading answer. For that reason an apparent completion is never reported straight away. Two further reads of the same location must each confirm it. If either confirming read disagrees, the job ends as a genuine failure.

A job that has not finished within a time budget ends with a timeout. The budget is set in microseconds and converted to a cycle count from the clock rate parameter. Each job ends with exactly one single-cycle pulse on `done`, `fail` or `timeout`.

The read path uses valid/ready on the request side. `rd_valid` rises with `rd_addr` and both stay unchanged until the cycle in which `rd_ready` is high; that cycle is the handshake. After the handshake the poller waits for one `rsp_valid` cycle that carries the byte read. It keeps at most one read outstanding. Response beats are accepted in every cycle, so the response side has no back-pressure.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `done`, `fail` and `timeout` are all low.
- R2: With `method`=0 and `erase`=0, a read counts as complete when bit DW-1 of `rsp_data` equals `prog_top_bit`. Other reads are followed by a new read of the same address.
- R3: With `method`=0 and `erase`=1, a read counts as complete when bit DW-1 of `rsp_data` is 1.
- R4: With `method`=1, the first read of a job only sets a baseline. Each later read counts as complete when bit DW-2 of `rsp_data` equals that bit in the previous read of the job.
- R5: After the first complete read, exactly two more reads are made. If both are complete, `done` pulses. A job whose first read is already complete therefore uses exactly 3 reads with `method`=0, and exactly 4 with `method`=1.
- R6: If either of the two confirming reads is not complete, `fail` pulses after that read and no further read is made.
- R7: If a non-complete read is evaluated once at least LIMIT = CLK_MHZ*BUDGET_US cycles have passed since the job started, `timeout` pulses instead of a new read.
- R8: Every job ends with exactly one pulse of one clock cycle on exactly one of `done`, `fail` or `timeout`. `busy` falls in the cycle after the pulse.
- R9: `start` is ignored while `busy` is high. All reads of a job use the `target_addr` captured when the job was accepted.
- R10: `rd_valid` and `rd_addr` hold steady until the handshake. No new request is raised before the response to the previous one. `rsp_valid` has no effect when no response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job when idle |
| method | input | 1 | 0 = data-bit polling, 1 = toggle detection |
| erase | input | 1 | Job is an erase (expected top bit is 1) |
| prog_top_bit | input | 1 | Top bit of the programmed byte |
| target_addr | input | AW | Location to poll |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read request address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DW | Read data |
| busy | output | 1 | Job in progress |
| done | output | 1 | Pulse: write confirmed complete |
| fail | output | 1 | Pulse: confirmation failed |
| timeout | output | 1 | Pulse: budget exceeded |

## Verification
A wrong confirmation count shows up directly in the number of read handshakes a job makes before its result pulse. It also shows as a result pulse raised one read too early or too late, visible within a few cycles of the deciding response. A wrong expected bit or a stale toggle baseline turns a `done` into a `fail` or into a polling loop that ends in `timeout` after LIMIT cycles. A captured address that drifts appears on `rd_addr` at the very next request. A poller that reacts to `start` or stray responses while not expecting them shows extra reads or spurious pulses within a few cycles.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_RESULT
  } poll_state_e;

  typedef enum logic [1:0] {
    RES_DONE,
    RES_FAIL,
    RES_TIMEOUT
  } poll_result_e;

  typedef enum logic {
    MTH_DATA_BIT = 1'b0,
    MTH_TOGGLE   = 1'b1
  } poll_method_e;

endpackage

// File: rtl/poll_judge.sv
module poll_judge
  import flash_poll_pkg::*;
(
  input  poll_method_e mode,
  input  logic         want_top,
  input  logic         got_top,
  input  logic         got_tog,
  input  logic         prev_tog,
  input  logic         have_prev,
  output logic         hit
);

  always_comb begin
    if (mode == MTH_TOGGLE) begin
      hit = have_prev && (got_tog == prev_tog);
    end else begin
      hit = (got_top == want_top);
    end
  end

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (run && count_q != LIM) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign expired = (count_q == LIM);

  a_r7_saturates : assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);

  a_r7_clear_rearms : assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int AW        = 18,
  parameter int DW        = 8,
  parameter int CLK_MHZ   = 250,
  parameter int BUDGET_US = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          method,
  input  logic          erase,
  input  logic          prog_top_bit,
  input  logic [AW-1:0] target_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          timeout
);

  localparam int LIMIT   = CLK_MHZ * BUDGET_US;
  localparam int TOP_BIT = DW - 1;
  localparam int TOG_BIT = DW - 2;

  poll_state_e  state_q;
  poll_result_e res_q;
  poll_method_e mode_q;
  logic         want_top_q;
  logic         top_q;
  logic         tog_q;
  logic         prev_tog_q;
  logic         have_prev_q;
  logic [1:0]   confirm_q;
  logic [AW-1:0] addr_q;
  logic         accept;
  logic         hit;
  logic         expired;

  assign accept = (state_q == ST_IDLE) && start;

  poll_judge u_judge (
    .mode      (mode_q),
    .want_top  (want_top_q),
    .got_top   (top_q),
    .got_tog   (tog_q),
    .prev_tog  (prev_tog_q),
    .have_prev (have_prev_q),
    .hit       (hit)
  );

  poll_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .run     (busy),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      res_q       <= RES_DONE;
      mode_q      <= MTH_DATA_BIT;
      want_top_q  <= 1'b0;
      top_q       <= 1'b0;
      tog_q       <= 1'b0;
      prev_tog_q  <= 1'b0;
      have_prev_q <= 1'b0;
      confirm_q   <= 2'd0;
      addr_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q      <= poll_method_e'(method);
            want_top_q  <= erase | prog_top_bit;
            addr_q      <= target_addr;
            confirm_q   <= 2'd0;
            have_prev_q <= 1'b0;
            state_q     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            top_q   <= rsp_data[TOP_BIT];
            tog_q   <= rsp_data[TOG_BIT];
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          prev_tog_q  <= tog_q;
          have_prev_q <= 1'b1;
          if (confirm_q != 2'd0) begin
            if (!hit) begin
              res_q   <= RES_FAIL;
              state_q <= ST_RESULT;
            end else if (confirm_q == 2'd2) begin
              res_q   <= RES_DONE;
              state_q <= ST_RESULT;
            end else begin
              confirm_q <= 2'd2;
              state_q   <= ST_ISSUE;
            end
          end else if (hit) begin
            confirm_q <= 2'd1;
            state_q   <= ST_ISSUE;
          end else if (expired) begin
            res_q   <= RES_TIMEOUT;
            state_q <= ST_RESULT;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_RESULT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (state_q == ST_ISSUE);
  assign rd_addr  = addr_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_RESULT) && (res_q == RES_DONE);
  assign fail     = (state_q == ST_RESULT) && (res_q == RES_FAIL);
  assign timeout  = (state_q == ST_RESULT) && (res_q == RES_TIMEOUT);

  a_r1_idle_after_reset : assert property (@(posedge clk)
    !rst_n |=> (!busy && !rd_valid && !done && !fail && !timeout));

  a_r8_one_result : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, timeout}));

  a_r8_single_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail || timeout) |=> !(done || fail || timeout) && !busy);

  a_r10_hold_request : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  a_r10_one_outstanding : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  a_r9_addr_fixed : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));

  a_r7_timeout_late : assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> expired);

endmodule

// File: tb/tb_flash_done_poller.sv
module tb_flash_done_poller;

  localparam int AW    = 18;
  localparam int DW    = 8;
  localparam int LIMIT = 250 * 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          method = 1'b0;
  logic          erase = 1'b0;
  logic          prog_top_bit = 1'b0;
  logic [AW-1:0] target_addr = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b1;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          busy, done, fail, timeout;

  always #2 clk = ~clk;

  flash_done_poller dut (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method), .erase(erase),
    .prog_top_bit(prog_top_bit), .target_addr(target_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .done(done), .fail(fail), .timeout(timeout)
  );

  typedef struct {
    int    kind;   // 0 done, 1 fail, 2 timeout
    int    reads;  // -1 = any
    string req;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] rsp_q[$];
  logic [DW-1:0] fill_byte = '0;
  logic [AW-1:0] cur_addr = '0;
  int  n_checks = 0;
  int  n_fail   = 0;
  int  n_reads  = 0;
  int  lat      = 0;
  bit  stall    = 1'b0;
  int  cyc      = 0;
  int  t_start  = 0;
  int  t_result = 0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Responder: read port model with optional back-pressure and latency
  initial begin
    bit            was_stalled = 1'b0;
    logic [AW-1:0] held_addr   = '0;
    forever begin
      @(negedge clk);
      if (was_stalled) begin
        chk(rd_valid == 1'b1 && rd_addr == held_addr, "R10",
            "request held under back-pressure", int'(rd_valid), 1);
      end
      rd_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      was_stalled = rd_valid && !rd_ready;
      held_addr   = rd_addr;
      if (rd_valid && rd_ready) begin
        n_reads++;
        chk(rd_addr == cur_addr, "R9", "read address",
            int'(rd_addr), int'(cur_addr));
        @(negedge clk);
        chk(!rd_valid, "R10", "no second request before response",
            int'(rd_valid), 0);
        repeat (lat) @(negedge clk);
        rsp_data  = (rsp_q.size() != 0) ? rsp_q.pop_front() : fill_byte;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        was_stalled = 1'b0;
      end
    end
  end

  // Monitor: scoreboard compare on result pulses
  initial begin
    bit prev_pulse = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_pulse) begin
        chk(!(done || fail || timeout) && !busy, "R8",
            "pulse lasts one cycle then idle", int'(busy), 0);
      end
      prev_pulse = done || fail || timeout;
      if (done || fail || timeout) begin
        int k;
        k = done ? 0 : (fail ? 1 : 2);
        t_result = cyc;
        chk(int'(done) + int'(fail) + int'(timeout) == 1, "R8",
            "one result line", int'(done) + int'(fail) + int'(timeout), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected result pulse", k, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(k == e.kind, e.req, "result kind", k, e.kind);
          if (e.reads >= 0)
            chk(n_reads == e.reads, e.req, "read count", n_reads, e.reads);
        end
      end
    end
  end

  task automatic run_job(input bit m, input bit er, input bit pbit,
                         input logic [AW-1:0] a, input int kind,
                         input int reads, input string req);
    exp_t e;
    e.kind = kind; e.reads = reads; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    n_reads = 0;
    cur_addr = a;
    method = m; erase = er; prog_top_bit = pbit; target_addr = a;
    start = 1'b1;
    t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, "job produced its result",
        exp_q.size(), 0);
    rsp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_valid && !done && !fail && !timeout, "R1",
        "outputs idle after reset", int'(busy) + int'(rd_valid), 0);

    // R2 program polling: two busy reads (top bit inverted) then matches
    rsp_q = '{8'h25, 8'h25, 8'hA5, 8'hA5, 8'hA5};
    run_job(1'b0, 1'b0, 1'b1, 18'h1_2345, 0, 5, "R2");

    // R2 with top bit 0 expected, latency and back-pressure
    lat = 2; stall = 1'b1;
    rsp_q = '{8'h80, 8'h00, 8'h7F, 8'h01};
    run_job(1'b0, 1'b0, 1'b0, 18'h0_0F00, 0, 4, "R2");
    lat = 0; stall = 1'b0;

    // R3 erase polling: top bit 0 while busy, 1 when finished
    rsp_q = '{8'h00, 8'h7F, 8'hFF, 8'h80, 8'hFF};
    run_job(1'b0, 1'b1, 1'b0, 18'h3_F000, 0, 5, "R3");

    // R5 polling complete at once: exactly 3 reads
    rsp_q = '{8'hA5, 8'hA5, 8'hA5};
    run_job(1'b0, 1'b0, 1'b1, 18'h0_0001, 0, 3, "R5");

    // R4 toggle: bit 6 flips, then settles
    lat = 1;
    rsp_q = '{8'h40, 8'h00, 8'h40, 8'h40, 8'h40, 8'h40};
    run_job(1'b1, 1'b0, 1'b0, 18'h2_AAAA, 0, 6, "R4");
    lat = 0;

    // R5 toggle constant data: baseline + apparent + two confirms = 4 reads
    rsp_q = '{8'h13, 8'h13, 8'h13, 8'h13};
    run_job(1'b1, 1'b0, 1'b0, 18'h1_5555, 0, 4, "R5");

    // R6 first confirm disagrees (polling)
    rsp_q = '{8'h25, 8'hA5, 8'h25};
    run_job(1'b0, 1'b0, 1'b1, 18'h0_1111, 1, 3, "R6");

    // R6 second confirm disagrees (polling)
    rsp_q = '{8'hA5, 8'hA5, 8'h25};
    run_job(1'b0, 1'b0, 1'b1, 18'h0_2222, 1, 3, "R6");

    // R6 toggle: bit 6 flips again during confirmation
    rsp_q = '{8'h00, 8'h00, 8'h40};
    run_job(1'b1, 1'b0, 1'b0, 18'h0_3333, 1, 3, "R6");

    // R9 start pulses during a job are ignored
    rsp_q = '{8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 8'h80};
    lat = 1;
    fork
      run_job(1'b0, 1'b0, 1'b1, 18'h0_4444, 0, 6, "R9");
      begin
        repeat (4) @(negedge clk);
        target_addr = 18'h3_9999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        target_addr = 18'h1_0000; method = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    lat = 0;

    // R10 stray responses while idle have no effect
    rsp_data = 8'hFF; rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !rd_valid, "R10", "stray response ignored",
        int'(busy) + int'(rd_valid), 0);

    // R7 timeout: top bit never reaches the expected value
    fill_byte = 8'h00;
    run_job(1'b0, 1'b0, 1'b1, 18'h2_0202, 2, -1, "R7");
    chk(t_result - t_start >= LIMIT && t_result - t_start <= LIMIT + 20,
        "R7", "cycles to timeout", t_result - t_start, LIMIT);

    // R8 a job after timeout still completes normally
    rsp_q = '{8'hFF, 8'hFF, 8'hFF};
    run_job(1'b0, 1'b1, 1'b0, 18'h0_0000, 0, 3, "R8");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

endmodule